// File: doc/BRIEF.md
# Coprocessor Handshake Stall Controller

This block is the processor-side sequencer for the execute phase of a coprocessor load/store instruction. A start pulse launches it with a base word address. From then on it reads a 2-bit handshake code from the coprocessor every cycle. The code decides the next step: take an undefined-instruction trap, keep stalling, begin or continue memory transfers, or finish.

While the instruction is alive, a pass output stays high. The coprocessor uses it to decide whether it may commit its own state. An interrupt that arrives while the controller is stalled abandons the instruction: pass drops and the controller goes back to idle. No transfer or trap takes place, so a later restart leaves no side effects.

During transfers the controller pulls an active-low memory request low and presents a word address. The address starts at the base and advances by one word per transfer. A one-cycle done pulse follows the final transfer.

Top module: `cop_hs_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it is released, `pass_o`=0, `mreq_n_o`=1, `undef_o`=0 and `done_o`=0. Reset acts at once, even in the middle of an instruction.
- R2: A `start_i` pulse while idle sets `pass_o` high in the next cycle. It also loads `addr_o` with the `base_addr_i` value sampled on that edge.
- R3: Handshake code 2'b00 (absent), seen while stalled before any transfer, gives the following outcome in the next cycle: `undef_o` high for exactly one cycle, `pass_o` low, and no memory request. The controller is then idle.
- R4: Handshake code 2'b01 (wait) with `irq_i` low keeps the controller stalled. `pass_o` stays high and `mreq_n_o` stays high, and the code is examined again in the next cycle.
- R5: Code 2'b01 with `irq_i` high abandons the instruction. In the next cycle `pass_o` is low, and no trap, done pulse or memory request appears. The controller is then idle.
- R6: Code 2'b10 (go) or 2'b11 (last), seen while stalled, makes the next cycle a transfer cycle: `mreq_n_o` low and `pass_o` high.
- R7: During a transfer cycle that is not the final one, code 2'b10 asks for at least one more transfer after the next. Any other code makes the next transfer the final one. The code presented during the final transfer is ignored.
- R8: Transfer number n (counting from 0) presents `addr_o` = base + 4·n, modulo 2^AW.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the final transfer, with `pass_o` low. The controller is idle afterwards.
- R10: `start_i` is ignored whenever the controller is not idle. This includes the done cycle and the trap cycle: the address and the sequence are not disturbed.
- R11: `irq_i` has no effect unless the code is 2'b01 while stalled. With code 2'b10 or 2'b11 the transfer still starts, and during transfers the interrupt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for one instruction |
| base_addr_i | input | AW | Word address of the first transfer |
| hs_i | input | 2 | Handshake code from the coprocessor |
| irq_i | input | 1 | Pending interrupt request |
| pass_o | output | 1 | High while the instruction may still commit |
| mreq_n_o | output | 1 | Memory request, low on a transfer cycle |
| addr_o | output | AW | Address of the current transfer |
| undef_o | output | 1 | One-cycle undefined-instruction trap request |
| done_o | output | 1 | One-cycle completion pulse after the final transfer |

## Verification
The properties assume that every input changes only between clock edges and holds a defined value once reset is released. The bench meets this by driving all inputs on the falling edge. The properties also assume that the coprocessor sends go/last codes during transfers. Other codes in that phase have a defined meaning (R7), and the bench applies them only in one directed test. Interrupts are held for a single stalled cycle or kept steady across a transfer run, so each abort or non-abort outcome can be traced to a single edge.

// File: rtl/cop_hs_pkg.sv
package cop_hs_pkg;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EXEC = 3'd1,
    ST_XFER = 3'd2,
    ST_DONE = 3'd3,
    ST_TRAP = 3'd4
  } st_e;

  // meaning of the handshake code for the current cycle
  typedef struct packed {
    logic trap;        // absent while stalled
    logic stall;       // wait, no interrupt
    logic abort;       // wait with interrupt
    logic launch;      // go or last while stalled
    logic first_final; // the first transfer is also the last
    logic more;        // during a transfer: another non-final one follows
  } hs_dec_t;

endpackage

// File: rtl/cop_hs_decode.sv
module cop_hs_decode
  import cop_hs_pkg::*;
(
  input  logic [1:0] hs_i,
  input  logic       irq_i,
  output hs_dec_t    dec_o
);

  hs_e code;
  assign code = hs_e'(hs_i);

  always_comb begin
    dec_o             = '0;
    dec_o.trap        = (code == HS_ABSENT);
    dec_o.stall       = (code == HS_WAIT) && !irq_i;
    dec_o.abort       = (code == HS_WAIT) &&  irq_i;
    dec_o.launch      = (code == HS_GO) || (code == HS_LAST);
    dec_o.first_final = (code == HS_LAST);
    dec_o.more        = (code == HS_GO);
  end

endmodule

// File: rtl/cop_hs_fsm.sv
module cop_hs_fsm
  import cop_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  hs_dec_t dec_i,
  output st_e     st_o,
  output logic    final_o
);

  st_e  st_q, st_d;
  logic fin_q, fin_d;

  always_comb begin
    st_d  = st_q;
    fin_d = fin_q;
    unique case (st_q)
      ST_IDLE: begin
        fin_d = 1'b0;
        if (start_i) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (dec_i.trap)        st_d = ST_TRAP;
        else if (dec_i.abort)  st_d = ST_IDLE;
        else if (dec_i.launch) begin
          st_d  = ST_XFER;
          fin_d = dec_i.first_final;
        end
        else if (dec_i.stall)  st_d = ST_EXEC;
      end
      ST_XFER: begin
        if (fin_q) begin
          st_d  = ST_DONE;
          fin_d = 1'b0;
        end else begin
          fin_d = !dec_i.more;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_TRAP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      fin_q <= fin_d;
    end
  end

  assign st_o    = st_q;
  assign final_o = fin_q;

endmodule

// File: rtl/cop_hs_addr.sv
module cop_hs_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] INC = AW'(STEP);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] cur);
    return cur + INC;
  endfunction

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (adv_i)  addr_q <= next_addr(addr_q);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/cop_hs_ctrl.sv
module cop_hs_ctrl
  import cop_hs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [1:0]    hs_i,
  input  logic          irq_i,
  output logic          pass_o,
  output logic          mreq_n_o,
  output logic [AW-1:0] addr_o,
  output logic          undef_o,
  output logic          done_o
);

  hs_dec_t dec;
  st_e     st;
  logic    fin;

  // named events for the checker
  logic in_exec, xfer_fire, abort_take, load_base;

  cop_hs_decode u_dec (
    .hs_i  (hs_i),
    .irq_i (irq_i),
    .dec_o (dec)
  );

  cop_hs_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .dec_i   (dec),
    .st_o    (st),
    .final_o (fin)
  );

  assign in_exec    = (st == ST_EXEC);
  assign xfer_fire  = (st == ST_XFER);
  assign abort_take = in_exec && dec.abort;
  assign load_base  = (st == ST_IDLE) && start_i;

  cop_hs_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_base),
    .base_i (base_addr_i),
    .adv_i  (xfer_fire),
    .addr_o (addr_o)
  );

  assign pass_o   = in_exec || xfer_fire;
  assign mreq_n_o = !xfer_fire;
  assign undef_o  = (st == ST_TRAP);
  assign done_o   = (st == ST_DONE) && !fin;

endmodule

// File: rtl/cop_hs_ctrl_chk.sv
module cop_hs_ctrl_chk #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] base_addr_i,
  input logic [1:0]    hs_i,
  input logic          irq_i,
  input logic          pass_o,
  input logic          mreq_n_o,
  input logic [AW-1:0] addr_o,
  input logic          undef_o,
  input logic          done_o,
  input logic          xfer_fire,
  input logic          abort_take
);

  logic stalled;
  assign stalled = pass_o && mreq_n_o;

  // R2
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_o && !done_o && !undef_o && start_i) |=> (pass_o && addr_o == $past(base_addr_i)));

  // R3
  p_absent_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && hs_i == 2'b00) |=> (undef_o && !pass_o && mreq_n_o));

  p_trap_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |=> !undef_o);

  // R4
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && hs_i == 2'b01 && !irq_i) |=> (pass_o && mreq_n_o));

  // R5
  p_irq_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> (!pass_o && !undef_o && !done_o && mreq_n_o));

  // R6 and R11: the interrupt does not stop a launch
  p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && hs_i[1]) |=> (!mreq_n_o && pass_o));

  // R8
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && $past(xfer_fire)) |-> (addr_o == $past(addr_o) + AW'(STEP)));

  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !pass_o));

  // R9 and R3: the trap, the done pulse and a transfer never coincide
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, undef_o, !mreq_n_o}));

endmodule

bind cop_hs_ctrl cop_hs_ctrl_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .base_addr_i (base_addr_i),
  .hs_i        (hs_i),
  .irq_i       (irq_i),
  .pass_o      (pass_o),
  .mreq_n_o    (mreq_n_o),
  .addr_o      (addr_o),
  .undef_o     (undef_o),
  .done_o      (done_o),
  .xfer_fire   (xfer_fire),
  .abort_take  (abort_take)
);

// File: tb/cop_hs_ctrl_test.sv
`timescale 1ns/1ps
module cop_hs_ctrl_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [1:0]    hs_i = 2'b01;
  logic          irq_i = 1'b0;
  logic          pass_o, mreq_n_o, undef_o, done_o;
  logic [AW-1:0] addr_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cop_hs_ctrl #(.AW(AW), .STEP(4)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .hs_i(hs_i), .irq_i(irq_i), .pass_o(pass_o), .mreq_n_o(mreq_n_o),
    .addr_o(addr_o), .undef_o(undef_o), .done_o(done_o)
  );

  // kind: 0 transfers, 1 absent trap, 2 interrupt abort
  // fields: [41:10] base, [9:6] wait cycles, [5:2] word count, [1:0] kind
  localparam int NV = 7;
  localparam logic [41:0] VECS [NV] = '{
    {32'h0000_0100, 4'd0, 4'd1, 2'd0},
    {32'h0000_2000, 4'd3, 4'd4, 2'd0},
    {32'h0000_0040, 4'd2, 4'd0, 2'd1},
    {32'h0000_0080, 4'd0, 4'd0, 2'd1},
    {32'h0000_0300, 4'd2, 4'd0, 2'd2},
    {32'hFFFF_FFF8, 4'd1, 4'd3, 2'd0},
    {32'h0000_0500, 4'd0, 4'd2, 2'd0}
  };

  function automatic logic [AW-1:0] want_addr(input logic [AW-1:0] b, input int n);
    return b + (AW'(n) << 2);
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input logic [AW-1:0] b);
    start_i = 1'b1; base_addr_i = b; hs_i = 2'b01;
    tick();
    start_i = 1'b0;
    chk("R2 pass after start", AW'(pass_o), 1);
    chk("R2 base loaded", addr_o, b);
  endtask

  task automatic run_vec(input logic [41:0] v);
    logic [AW-1:0] b;
    int waits, words, kind;
    b = v[41:10]; waits = int'(v[9:6]); words = int'(v[5:2]); kind = int'(v[1:0]);
    launch(b);
    for (int w = 0; w < waits; w++) begin
      tick();
      chk("R4 stall pass", AW'(pass_o), 1);
      chk("R4 stall no request", AW'(mreq_n_o), 1);
    end
    if (kind == 1) begin
      hs_i = 2'b00;
      tick();
      hs_i = 2'b01;
      chk("R3 trap raised", AW'(undef_o), 1);
      chk("R3 pass low", AW'(pass_o), 0);
      chk("R3 no request", AW'(mreq_n_o), 1);
      tick();
      chk("R3 trap one cycle", AW'(undef_o), 0);
    end else if (kind == 2) begin
      irq_i = 1'b1;
      tick();
      irq_i = 1'b0;
      chk("R5 pass dropped", AW'(pass_o), 0);
      chk("R5 no trap", AW'(undef_o), 0);
      chk("R5 no request", AW'(mreq_n_o), 1);
      tick();
      chk("R5 no done", AW'(done_o), 0);
    end else begin
      hs_i = (words == 1) ? 2'b11 : 2'b10;
      tick();
      for (int i = 0; i < words; i++) begin
        chk("R6 transfer request", AW'(mreq_n_o), 0);
        chk("R8 transfer address", addr_o, want_addr(b, i));
        if (i == words - 1) hs_i = 2'b01;
        else hs_i = (i == words - 2) ? 2'b11 : 2'b10;
        tick();
      end
      chk("R9 done pulse", AW'(done_o), 1);
      chk("R9 pass low at done", AW'(pass_o), 0);
      chk("R7 no extra transfer", AW'(mreq_n_o), 1);
      tick();
      chk("R9 done one cycle", AW'(done_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pass in reset", AW'(pass_o), 0);
    chk("R1 request in reset", AW'(mreq_n_o), 1);
    rst_n = 1'b1;
    tick();
    chk("R1 trap idle", AW'(undef_o), 0);
    chk("R1 done idle", AW'(done_o), 0);
    chk("R1 pass idle", AW'(pass_o), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10: start while stalled and at done is ignored
    launch(32'h0000_7000);
    start_i = 1'b1; base_addr_i = 32'hDEAD_0000;
    tick();
    start_i = 1'b0;
    chk("R10 address kept", addr_o, 32'h0000_7000);
    hs_i = 2'b11;
    tick();
    hs_i = 2'b01;
    chk("R10 transfer from old base", addr_o, 32'h0000_7000);
    tick();
    chk("R10 done reached", AW'(done_o), 1);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R10 start at done ignored", AW'(pass_o), 0);

    // R11 and R7: interrupt during launch, non-go code during a transfer
    launch(32'h0000_0A00);
    irq_i = 1'b1; hs_i = 2'b10;
    tick();
    chk("R11 launch despite interrupt", AW'(mreq_n_o), 0);
    chk("R11 pass held", AW'(pass_o), 1);
    hs_i = 2'b00;
    tick();
    chk("R7 absent means final follows", AW'(mreq_n_o), 0);
    chk("R7 second address", addr_o, 32'h0000_0A04);
    hs_i = 2'b10;
    tick();
    irq_i = 1'b0; hs_i = 2'b01;
    chk("R7 code ignored on final", AW'(done_o), 1);
    tick();

    // R1: reset in the middle of an instruction
    launch(32'h0000_0C00);
    rst_n = 1'b0;
    #1;
    chk("R1 async pass", AW'(pass_o), 0);
    chk("R1 async request", AW'(mreq_n_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 stays idle", AW'(pass_o), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule